// File: doc/BRIEF.md
# Multi-Port Event Interrupt Aggregator

This block collects event pulses from several ports and folds them into one active-low interrupt line. Each port holds a sticky status register, an event enable mask and a two-bit control register. A status bit sets when its event pulse arrives and stays set until software reads that port's status register. The read returns the bits and clears them. A port raises a request when its port interrupt enable is set and either an enabled status bit is set or its force bit is set. All port requests are ORed together.

The combined request drives a two-state machine. In `IRQ_IDLE` the pin is high. The `RAISE` transition moves to `IRQ_ACTIVE` on the first clock edge that sees any port request. In `IRQ_ACTIVE` the pin is low. The `DROP` transition returns to `IRQ_IDLE` on the first edge that sees no request. The pin comes straight from the state register, so it cannot glitch.

Software reaches the registers through a simple bus: an address, a write strobe with write data, and a read strobe. Read data is registered and appears one cycle after the strobe.

Top module: `irq_agg`

## Requirements
- R1: After reset, every status, enable and control register reads 0, `bus_rdata_o` is 0 and `irq_n_o` is high.
- R2: A high bit on `evt_i` for one cycle sets the matching status bit, whatever the enable state. The bit stays set until a status read of that port.
- R3: A read strobe to a port's status register returns its bits in `bus_rdata_o` one clock later and clears the register at that same edge.
- R4: An event arriving in the same cycle as a clearing read leaves its bit set. That read returns only the bits that were set before it.
- R5: Address bits [4:2] select the port (0 to 5) and bits [1:0] select the register: 0 is status (read-only), 1 is enable (read/write), 2 is control (read/write, bit 0 force, bit 1 port interrupt enable, upper bits read 0). Register selector 3, ports 6 and 7, and writes to status read back 0 or have no effect.
- R6: A set status bit whose enable bit is 0 does not assert the interrupt.
- R7: With its port interrupt enable set, a port's force bit asserts the interrupt even with no status set.
- R8: A port whose interrupt enable is 0 never asserts the interrupt, even with its force bit set or an enabled status bit set.
- R9: `irq_n_o` goes low one clock after any port request appears. It goes high one clock after the last request goes away, and it stays low while any port still requests.
- R10: Reading the enable or control register leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| evt_i | input | 48 | Event pulses; port p uses bits [8p+7:8p] |
| bus_addr_i | input | 5 | Register address: port in [4:2], register in [1:0] |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rd_i | input | 1 | Read strobe; a status read clears the register |
| bus_rdata_o | output | 8 | Registered read data, valid one cycle after the strobe |
| irq_n_o | output | 1 | Combined interrupt, active low, registered |

## Verification
The hardest case to reach is an event that lands in the same clock cycle as the read that clears its port's status. The bench drives the event pulse and the status read strobe on the same falling edge. It then checks that the read returned only the older bit and that a second read returns the new one. Timing of the pin is also hard to see from outside. The bench therefore samples `irq_n_o` both right after a request appears and one cycle later, and does the same when a request clears. This shows the one-cycle lag of each `RAISE` and `DROP` transition.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    localparam int CTRL_FORCE = 0;
    localparam int CTRL_PEN   = 1;
    localparam int CTRL_W     = 2;

endpackage

// File: rtl/irq_agg_port.sv
module irq_agg_port
    import irq_agg_pkg::*;
#(
    parameter int NUM_EVENTS = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic [NUM_EVENTS-1:0] evt_i,
    input  logic                  sel_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  reg_sel_e              reg_i,
    input  logic [NUM_EVENTS-1:0] wdata_i,
    output logic [NUM_EVENTS-1:0] status_o,
    output logic [NUM_EVENTS-1:0] enable_o,
    output logic [CTRL_W-1:0]     ctrl_o,
    output logic                  req_o
);

    logic clr;
    logic [NUM_EVENTS-1:0] status_q;
    logic [NUM_EVENTS-1:0] enable_q;
    logic [CTRL_W-1:0]     ctrl_q;

    assign clr = sel_i && rd_i && (reg_i == REG_STATUS);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~{NUM_EVENTS{clr}}) | evt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            enable_q <= '0;
            ctrl_q   <= '0;
        end else if (sel_i && wr_i) begin
            if (reg_i == REG_ENABLE) enable_q <= wdata_i;
            if (reg_i == REG_CTRL)   ctrl_q   <= wdata_i[CTRL_W-1:0];
        end
    end

    always_comb begin
        req_o = ctrl_q[CTRL_PEN] &&
                (ctrl_q[CTRL_FORCE] || (|(status_q & enable_q)));
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign ctrl_o   = ctrl_q;

    AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !clr |=> ((status_q & $past(status_q)) == $past(status_q))); // R2
    AST_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R4
    AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clr && evt_i == '0) |=> (status_q == '0)); // R3

endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine
    import irq_agg_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    input  logic [NUM_PORTS-1:0] req_i,
    output logic                 irq_n_o
);

    irq_state_e state_q, state_d;
    logic any_req;

    assign any_req = |req_i;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= IRQ_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_req)  state_d = IRQ_ACTIVE;  // RAISE
            IRQ_ACTIVE: if (!any_req) state_d = IRQ_IDLE;    // DROP
        endcase
    end

    always_comb begin
        irq_n_o = (state_q != IRQ_ACTIVE);
    end

    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        any_req |=> !irq_n_o); // R9
    AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !any_req |=> irq_n_o); // R9

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_PORTS  = 6,
    parameter int NUM_EVENTS = 8,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W    = PORT_W + 2
) (
    input  logic                            clk_i,
    input  logic                            rst_n_i,
    input  logic [NUM_PORTS*NUM_EVENTS-1:0] evt_i,
    input  logic [ADDR_W-1:0]               bus_addr_i,
    input  logic                            bus_wr_i,
    input  logic [NUM_EVENTS-1:0]           bus_wdata_i,
    input  logic                            bus_rd_i,
    output logic [NUM_EVENTS-1:0]           bus_rdata_o,
    output logic                            irq_n_o
);

    logic [PORT_W-1:0]     port_idx;
    reg_sel_e              reg_sel;
    logic [NUM_EVENTS-1:0] status_w [NUM_PORTS];
    logic [NUM_EVENTS-1:0] enable_w [NUM_PORTS];
    logic [CTRL_W-1:0]     ctrl_w   [NUM_PORTS];
    logic [NUM_PORTS-1:0]  req_w;
    logic [NUM_EVENTS-1:0] rd_mux;
    logic [NUM_EVENTS-1:0] rdata_q;

    assign port_idx = bus_addr_i[ADDR_W-1:2];
    assign reg_sel  = reg_sel_e'(bus_addr_i[1:0]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        irq_agg_port #(.NUM_EVENTS(NUM_EVENTS)) u_port (
            .clk_i    (clk_i),
            .rst_n_i  (rst_n_i),
            .evt_i    (evt_i[p*NUM_EVENTS +: NUM_EVENTS]),
            .sel_i    (port_idx == PORT_W'(p)),
            .wr_i     (bus_wr_i),
            .rd_i     (bus_rd_i),
            .reg_i    (reg_sel),
            .wdata_i  (bus_wdata_i),
            .status_o (status_w[p]),
            .enable_o (enable_w[p]),
            .ctrl_o   (ctrl_w[p]),
            .req_o    (req_w[p])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_idx == PORT_W'(p)) begin
                case (reg_sel)
                    REG_STATUS: rd_mux = status_w[p];
                    REG_ENABLE: rd_mux = enable_w[p];
                    REG_CTRL:   rd_mux = NUM_EVENTS'(ctrl_w[p]);
                    default:    rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)      rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_mux;
    end

    assign bus_rdata_o = rdata_q;

    irq_agg_combine #(.NUM_PORTS(NUM_PORTS)) u_combine (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .req_i   (req_w),
        .irq_n_o (irq_n_o)
    );

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (bus_rd_i && reg_sel == REG_NONE) |=> (bus_rdata_o == '0)); // R5

endmodule

// File: tb/irq_agg_bench.sv
module irq_agg_bench;

    localparam int NP = 6;
    localparam int NE = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP*NE-1:0] evt = '0;
    logic [4:0]      addr = '0;
    logic            wr = 1'b0;
    logic [NE-1:0]   wdata = '0;
    logic            rd = 1'b0;
    logic [NE-1:0]   rdata;
    logic            irq_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    irq_agg u_irq_agg (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .evt_i       (evt),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_n_o     (irq_n)
    );

    localparam logic [1:0] RS = 2'd0, RE = 2'd1, RC = 2'd2, RX = 2'd3;

    function automatic logic [4:0] a(input int p, input logic [1:0] r);
        return {3'(p), r};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] ad, input logic [NE-1:0] d);
        addr = ad; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] ad, output logic [NE-1:0] d);
        addr = ad; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input int p, input logic [NE-1:0] bits);
        evt[p*NE +: NE] = bits;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [NE-1:0] d;
        chk("R1 rdata", int'(rdata), 0);
        chk("R1 irq_n", int'(irq_n), 1);
        bus_read(a(0, RS), d); chk("R1 status p0", int'(d), 0);
        bus_read(a(5, RE), d); chk("R1 enable p5", int'(d), 0);
        bus_read(a(3, RC), d); chk("R1 ctrl p3", int'(d), 0);
    endtask

    task automatic t_sticky_clear();
        logic [NE-1:0] d;
        pulse(1, 8'h05);
        repeat (3) @(negedge clk);
        chk("R6 no enable no irq", int'(irq_n), 1);
        bus_read(a(1, RS), d); chk("R2 sticky status", int'(d), 'h05);
        bus_read(a(1, RS), d); chk("R3 cleared by read", int'(d), 0);
    endtask

    task automatic t_mask_and_timing();
        logic [NE-1:0] d;
        bus_write(a(2, RE), 8'h10);
        bus_write(a(2, RC), 8'h02);
        pulse(2, 8'h01);
        @(negedge clk);
        chk("R6 masked event", int'(irq_n), 1);
        pulse(2, 8'h10);
        chk("R9 registered, not yet low", int'(irq_n), 1);
        @(negedge clk);
        chk("R9 low one clock later", int'(irq_n), 0);
        bus_read(a(2, RE), d); chk("R5 enable readback", int'(d), 'h10);
        bus_read(a(2, RC), d); chk("R5 ctrl readback", int'(d), 'h02);
        bus_write(a(2, RS), 8'hFF);
        bus_read(a(2, RS), d); chk("R2 status holds both", int'(d), 'h11);
        chk("R9 still low at clear edge", int'(irq_n), 0);
        @(negedge clk);
        chk("R9 high one clock after clear", int'(irq_n), 1);
        bus_read(a(2, RS), d); chk("R5 status write ignored", int'(d), 0);
    endtask

    task automatic t_clear_race();
        logic [NE-1:0] d;
        pulse(0, 8'h01);
        addr = a(0, RS); rd = 1'b1; evt[0 +: NE] = 8'h80;
        @(negedge clk);
        rd = 1'b0; evt = '0;
        chk("R4 race read returns old bits", int'(rdata), 'h01);
        bus_read(a(0, RS), d); chk("R4 racing event kept", int'(d), 'h80);
        bus_read(a(0, RS), d); chk("R3 clear after race", int'(d), 0);
    endtask

    task automatic t_force_gate();
        logic [NE-1:0] d;
        bus_write(a(4, RC), 8'h01);
        repeat (2) @(negedge clk);
        chk("R8 force without port enable", int'(irq_n), 1);
        bus_write(a(4, RC), 8'h03);
        @(negedge clk);
        chk("R7 force asserts irq", int'(irq_n), 0);
        bus_write(a(4, RC), 8'h01);
        @(negedge clk);
        chk("R8 port enable cleared drops irq", int'(irq_n), 1);
        bus_write(a(4, RE), 8'hFF);
        bus_write(a(4, RC), 8'h00);
        pulse(4, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R8 enabled status gated", int'(irq_n), 1);
        bus_read(a(4, RS), d); chk("R2 status set though gated", int'(d), 'hFF);
    endtask

    task automatic t_map();
        logic [NE-1:0] d;
        bus_write(a(5, RE), 8'hA5);
        bus_read(a(5, RE), d); chk("R5 enable p5", int'(d), 'hA5);
        bus_write(a(5, RC), 8'hFF);
        bus_read(a(5, RC), d); chk("R5 ctrl upper bits zero", int'(d), 'h03);
        bus_write(a(5, RC), 8'h00);
        bus_write(a(5, RX), 8'h77);
        bus_read(a(5, RX), d); chk("R5 selector 3 reads zero", int'(d), 0);
        bus_write(a(6, RE), 8'h33);
        bus_read(a(6, RE), d); chk("R5 port 6 reads zero", int'(d), 0);
        bus_write(a(7, RC), 8'h33);
        bus_read(a(7, RC), d); chk("R5 port 7 reads zero", int'(d), 0);
        bus_read(a(0, RE), d); chk("R5 p0 enable untouched", int'(d), 0);
        bus_read(a(5, RE), d); chk("R5 p5 enable untouched", int'(d), 'hA5);
    endtask

    task automatic t_no_side_clear();
        logic [NE-1:0] d;
        pulse(3, 8'h40);
        bus_read(a(3, RE), d);
        bus_read(a(3, RC), d);
        bus_read(a(3, RS), d); chk("R10 status kept after other reads", int'(d), 'h40);
    endtask

    task automatic t_multi_port();
        logic [NE-1:0] d;
        bus_write(a(0, RE), 8'h02);
        bus_write(a(0, RC), 8'h02);
        bus_write(a(5, RC), 8'h02);
        evt[0 +: NE] = 8'h02; evt[5*NE +: NE] = 8'h20;
        @(negedge clk);
        evt = '0;
        @(negedge clk);
        chk("R9 two ports low", int'(irq_n), 0);
        bus_read(a(0, RS), d);
        @(negedge clk);
        chk("R9 one port still requests", int'(irq_n), 0);
        bus_read(a(5, RS), d); chk("R3 p5 status", int'(d), 'h20);
        @(negedge clk);
        chk("R9 high after last clear", int'(irq_n), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky_clear();
        t_mask_and_timing();
        t_clear_race();
        t_force_gate();
        t_map();
        t_no_side_clear();
        t_multi_port();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule